// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block runs the link training handshake of a DisplayPort source for one, two or four lanes. It does not touch the PHY itself. It talks to the sink's configuration registers through an abstract single-byte request port, which a separate AUX engine services. It presents the chosen link rate, lane count, training pattern and per-lane drive bytes as plain outputs for the analog front end.

A pulse on `start_i` latches the lane count and the starting rate, and the sequence then runs on its own:
- It configures the sink and drives pattern 1 until every active lane reports clock recovery.
- It switches to pattern 2 and iterates until equalization, symbol lock and inter-lane alignment are all reported.
- Throughout, it follows the sink's per-lane swing and pre-emphasis requests.
- If clock recovery stalls or equalization runs too long, it drops from 2.7 Gb/s to 1.62 Gb/s and restarts.
- If it is already at the low rate, it switches the pattern off and reports failure.

Top module: `dp_link_trainer`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o`, `req_o` and `tps_o` are 0, `lane_ctl_o` is 0 and `link_rate_o` is 0x06.
- R2: A start pulse latches `lanes_i` and selects rate code 0x0A (`hbr_en_i`=1) or 0x06. It sets `tps_o`=1 and clears all lane bytes and counters. It then writes, in order: 0x600=0x01, 0x100=rate code, 0x101=lane count, 0x102=0x21, and 0x103..0x106=0x00.
- R3: Each access moves one byte. `req_o`, `we_o`, `addr_o` and `wdata_o` hold steady until the cycle in which `ack_i` is high.
- R4: Each training iteration reads 0x202, 0x203, 0x204, 0x206 and 0x207, in that order. Lane n's status nibble sits at bits [4*(n%2)+3 : 4*(n%2)] of byte 0x202+n/2. Status bit 0 means clock recovery done, bit 1 means equalization done and bit 2 means symbol lock. If any active lane's nibble differs from lane 0's, the block fails. Inactive lanes are ignored.
- R5: Lane n's adjust request is the nibble of byte 0x206+n/2 at the same position as its status nibble, with swing in bits [1:0] and pre-emphasis in bits [3:2]. Its drive byte is pre-emphasis<<3 | swing. When either field equals 3, bits 2 and 5 are also set. Inactive lanes get 0. `lane_ctl_o` byte n holds lane n.
- R6: In clock recovery with the done bit set, the block takes the new drive bytes and sets `tps_o`=2. It writes 0x102=0x22 and then 0x103..0x106, and enters equalization.
- R7: In clock recovery without the done bit, an active lane whose request equals its current drive setting increments its counter. A request at level 3 on any active lane, or a counter reaching MAX_CR, causes a rate reduction. Otherwise the new bytes are written to 0x103..0x106 and the phase repeats.
- R8: Equalization succeeds when clock recovery, equalization and symbol lock are all set in the nibble and bit 0 of 0x204 is set. The block then shows `done_o`=1, keeps its rate and issues no further access.
- R9: A failed equalization iteration increments a loop counter. Once the counter would exceed MAX_EQ, the block reduces the rate. Otherwise it writes the new bytes to 0x103..0x106 and repeats.
- R10: During equalization, a cleared clock-recovery bit causes a rate reduction.
- R11: A rate reduction at 0x0A sets the rate to 0x06 and restarts from the R2 sequence. At 0x06 it writes 0x102=0x00 and ends with `fail_o`=1 and `tps_o`=0.
- R12: An access completed with `err_i`=1 sends the block to failure in the next cycle with `tps_o`=0, and no further access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken when not busy |
| hbr_en_i | input | 1 | Start at 2.7 Gb/s when 1, else 1.62 Gb/s |
| lanes_i | input | 3 | Lane count: 1, 2 or 4 |
| busy_o | output | 1 | Training in progress |
| done_o | output | 1 | Training succeeded |
| fail_o | output | 1 | Training failed |
| link_rate_o | output | 8 | Current rate code (0x0A or 0x06) |
| lane_count_o | output | 3 | Latched lane count |
| tps_o | output | 2 | Local training pattern (0 off, 1, 2) |
| lane_ctl_o | output | 32 | Drive byte per lane, lane 0 in bits [7:0] |
| req_o | output | 1 | Sink register access request |
| we_o | output | 1 | Access is a write |
| addr_o | output | 20 | Sink register address |
| wdata_o | output | 8 | Write byte |
| ack_i | input | 1 | Access completes this cycle |
| err_i | input | 1 | Completing access returned an error |
| rdata_i | input | 8 | Read byte, valid with ack_i |

## Verification
The bench builds the block with MAX_CR=3 and MAX_EQ=2. With these limits, repeated-setting exhaustion in clock recovery and loop exhaustion in equalization each take only a few iterations, so both fallback paths are exercised at both rates. A behavioural sink model answers every access, checks each address and data byte against its own walk through the training rules, and stalls acknowledges for varying lengths. The scenarios cover lane counts of one, two and four, status disagreement on active and inactive lanes, level-3 requests, clock-recovery loss, error responses and success at either rate.

// File: rtl/dplt_pkg.sv
package dplt_pkg;
  localparam int unsigned SINK_AW = 20;
  localparam int unsigned NLANE   = 4;

  localparam logic [7:0] RATE_HI = 8'h0A;
  localparam logic [7:0] RATE_LO = 8'h06;

  localparam logic [SINK_AW-1:0] A_PWR   = 20'h00600;
  localparam logic [SINK_AW-1:0] A_BW    = 20'h00100;
  localparam logic [SINK_AW-1:0] A_LCNT  = 20'h00101;
  localparam logic [SINK_AW-1:0] A_PAT   = 20'h00102;
  localparam logic [SINK_AW-1:0] A_DRV0  = 20'h00103;

  localparam logic [7:0] PWR_D0   = 8'h01;
  localparam logic [7:0] PAT_TPS1 = 8'h21;
  localparam logic [7:0] PAT_TPS2 = 8'h22;
  localparam logic [7:0] PAT_OFF  = 8'h00;

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_RD, S_EVAL, S_WR, S_DIS, S_DONE, S_FAIL
  } st_t;

  // read order per iteration: status pair, align, adjust pair
  function automatic logic [SINK_AW-1:0] rd_addr(input logic [2:0] step);
    case (step)
      3'd0:    rd_addr = 20'h00202;
      3'd1:    rd_addr = 20'h00203;
      3'd2:    rd_addr = 20'h00204;
      3'd3:    rd_addr = 20'h00206;
      default: rd_addr = 20'h00207;
    endcase
  endfunction
endpackage

// File: rtl/dplt_lane_status.sv
module dplt_lane_status #(
  parameter int unsigned NL = 4
) (
  input  logic [NL*4-1:0] stat_i,
  input  logic [NL-1:0]   act_i,
  output logic [3:0]      nib0_o,
  output logic            mism_o
);
  logic [NL-1:0] diff;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign diff[l] = act_i[l] && (stat_i[l*4 +: 4] != stat_i[3:0]);
  end

  assign nib0_o = stat_i[3:0];
  assign mism_o = |diff;
endmodule

// File: rtl/dplt_adj_decode.sv
module dplt_adj_decode #(
  parameter int unsigned NL = 4
) (
  input  logic [NL*4-1:0] adj_i,
  input  logic [NL-1:0]   act_i,
  input  logic [NL*8-1:0] cur_i,
  output logic [NL*8-1:0] ctl_o,
  output logic            max3_o,
  output logic [NL-1:0]   same_o
);
  logic [NL-1:0] top;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [1:0] sw, em;
    assign sw      = adj_i[l*4 +: 2];
    assign em      = adj_i[l*4+2 +: 2];
    assign top[l]  = act_i[l] && (sw == 2'd3 || em == 2'd3);
    assign ctl_o[l*8 +: 8] = act_i[l] ? {2'b00, top[l], em, top[l], sw} : 8'h00;
    assign same_o[l] = act_i[l] && (cur_i[l*8 +: 2] == sw) && (cur_i[l*8+3 +: 2] == em);
  end

  assign max3_o = |top;
endmodule

// File: rtl/dplt_cr_counters.sv
module dplt_cr_counters #(
  parameter int unsigned NL     = 4,
  parameter int unsigned MAX_CR = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [NL-1:0] same_i,
  output logic          hit_o
);
  localparam int unsigned CW = $clog2(MAX_CR + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_CR - 1);

  logic [NL-1:0] near;

  for (genvar l = 0; l < NL; l++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt_q <= '0;
      else if (clr_i)               cnt_q <= '0;
      else if (inc_i && same_i[l])  cnt_q <= cnt_q + 1'b1;
    end
    assign near[l] = same_i[l] && (cnt_q == LAST);
  end

  assign hit_o = |near;
endmodule

// File: rtl/dp_link_trainer.sv
module dp_link_trainer
  import dplt_pkg::*;
#(
  parameter int unsigned MAX_CR = 5,
  parameter int unsigned MAX_EQ = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        hbr_en_i,
  input  logic [2:0]  lanes_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        fail_o,
  output logic [7:0]  link_rate_o,
  output logic [2:0]  lane_count_o,
  output logic [1:0]  tps_o,
  output logic [31:0] lane_ctl_o,
  output logic        req_o,
  output logic        we_o,
  output logic [19:0] addr_o,
  output logic [7:0]  wdata_o,
  input  logic        ack_i,
  input  logic        err_i,
  input  logic [7:0]  rdata_i
);
  localparam int unsigned EQW = $clog2(MAX_EQ + 2);
  localparam logic [EQW-1:0] EQ_LAST = EQW'(MAX_EQ);

  st_t                  st_q;
  logic [2:0]           step_q;
  logic                 eq_ph_q;
  logic [7:0]           rate_q;
  logic [2:0]           lanes_q;
  logic [1:0]           tps_q;
  logic [NLANE*8-1:0]   ctl_q;
  logic [4:0][7:0]      rd_q;
  logic [EQW-1:0]       eq_cnt_q;

  logic [NLANE-1:0]     act, same;
  logic [NLANE*8-1:0]   ctl_new;
  logic [3:0]           nib0;
  logic                 mism, any_max3, cr_hit;

  for (genvar l = 0; l < NLANE; l++) begin : g_act
    assign act[l] = (3'(l) < lanes_q);
  end

  dplt_lane_status #(.NL(NLANE)) u_stat (
    .stat_i ({rd_q[1], rd_q[0]}),
    .act_i  (act),
    .nib0_o (nib0),
    .mism_o (mism)
  );

  dplt_adj_decode #(.NL(NLANE)) u_adj (
    .adj_i  ({rd_q[4], rd_q[3]}),
    .act_i  (act),
    .cur_i  (ctl_q),
    .ctl_o  (ctl_new),
    .max3_o (any_max3),
    .same_o (same)
  );

  logic eval_cr, eval_eq, cr_ok, eq_ok, need_red, red_hi, launch, cr_clr, cr_inc;
  logic acc, idle_like;

  assign idle_like = (st_q == S_IDLE) || (st_q == S_DONE) || (st_q == S_FAIL);
  assign acc       = (st_q == S_INIT) || (st_q == S_RD) || (st_q == S_WR) || (st_q == S_DIS);
  assign eval_cr   = (st_q == S_EVAL) && !eq_ph_q;
  assign eval_eq   = (st_q == S_EVAL) &&  eq_ph_q;
  assign cr_ok     = nib0[0];
  assign eq_ok     = nib0[0] && nib0[1] && nib0[2] && rd_q[2][0];
  assign need_red  = !mism && ((eval_cr && !cr_ok && (any_max3 || cr_hit)) ||
                               (eval_eq && (!cr_ok || (!eq_ok && eq_cnt_q >= EQ_LAST))));
  assign red_hi    = need_red && (rate_q == RATE_HI);
  assign launch    = idle_like && start_i;
  assign cr_clr    = launch || red_hi;
  assign cr_inc    = eval_cr && !mism && !cr_ok && !any_max3 && !cr_hit;

  dplt_cr_counters #(.NL(NLANE), .MAX_CR(MAX_CR)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cr_clr),
    .inc_i  (cr_inc),
    .same_i (same),
    .hit_o  (cr_hit)
  );

  // access decode
  always_comb begin
    we_o    = 1'b1;
    addr_o  = A_PAT;
    wdata_o = PAT_OFF;
    unique case (st_q)
      S_INIT: begin
        unique case (step_q)
          3'd0:    begin addr_o = A_PWR;  wdata_o = PWR_D0;          end
          3'd1:    begin addr_o = A_BW;   wdata_o = rate_q;          end
          3'd2:    begin addr_o = A_LCNT; wdata_o = {5'b0, lanes_q}; end
          3'd3:    begin addr_o = A_PAT;  wdata_o = PAT_TPS1;        end
          default: begin
            addr_o  = A_DRV0 + 20'(step_q - 3'd4);
            wdata_o = ctl_q[(step_q - 3'd4)*8 +: 8];
          end
        endcase
      end
      S_RD: begin we_o = 1'b0; addr_o = rd_addr(step_q); wdata_o = 8'h00; end
      S_WR: begin
        if (step_q == 3'd0) begin
          addr_o = A_PAT; wdata_o = PAT_TPS2;
        end else begin
          addr_o  = A_DRV0 + 20'(step_q - 3'd1);
          wdata_o = ctl_q[(step_q - 3'd1)*8 +: 8];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      step_q   <= '0;
      eq_ph_q  <= 1'b0;
      rate_q   <= RATE_LO;
      lanes_q  <= '0;
      tps_q    <= 2'd0;
      ctl_q    <= '0;
      rd_q     <= '0;
      eq_cnt_q <= '0;
    end else if (acc && ack_i && err_i) begin
      st_q  <= S_FAIL;
      tps_q <= 2'd0;
    end else if (cr_clr) begin
      if (launch) begin
        rate_q  <= hbr_en_i ? RATE_HI : RATE_LO;
        lanes_q <= lanes_i;
      end else begin
        rate_q  <= RATE_LO;
      end
      st_q     <= S_INIT;
      step_q   <= '0;
      eq_ph_q  <= 1'b0;
      tps_q    <= 2'd1;
      ctl_q    <= '0;
      eq_cnt_q <= '0;
    end else begin
      unique case (st_q)
        S_INIT: if (ack_i) begin
          if (step_q == 3'd7) begin st_q <= S_RD; step_q <= '0; end
          else step_q <= step_q + 3'd1;
        end
        S_RD: if (ack_i) begin
          rd_q[step_q] <= rdata_i;
          if (step_q == 3'd4) st_q <= S_EVAL;
          else step_q <= step_q + 3'd1;
        end
        S_EVAL: begin
          if (mism) begin
            st_q <= S_FAIL; tps_q <= 2'd0;
          end else if (need_red) begin
            st_q <= S_DIS;
          end else if (!eq_ph_q) begin
            ctl_q <= ctl_new;
            st_q  <= S_WR;
            if (cr_ok) begin
              tps_q <= 2'd2; eq_ph_q <= 1'b1; step_q <= 3'd0;
            end else begin
              step_q <= 3'd1;
            end
          end else if (eq_ok) begin
            st_q <= S_DONE;
          end else begin
            eq_cnt_q <= eq_cnt_q + 1'b1;
            ctl_q    <= ctl_new;
            st_q     <= S_WR;
            step_q   <= 3'd1;
          end
        end
        S_WR: if (ack_i) begin
          if (step_q == 3'd4) begin st_q <= S_RD; step_q <= '0; end
          else step_q <= step_q + 3'd1;
        end
        S_DIS: if (ack_i) begin
          st_q <= S_FAIL; tps_q <= 2'd0;
        end
        default: ;
      endcase
    end
  end

  assign req_o        = acc;
  assign busy_o       = !idle_like;
  assign done_o       = (st_q == S_DONE);
  assign fail_o       = (st_q == S_FAIL);
  assign link_rate_o  = rate_q;
  assign lane_count_o = lanes_q;
  assign tps_o        = tps_q;
  assign lane_ctl_o   = ctl_q;
endmodule

// File: rtl/dplt_checker.sv
module dplt_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        fail_o,
  input logic [7:0]  link_rate_o,
  input logic [1:0]  tps_o,
  input logic        req_o,
  input logic        we_o,
  input logic [19:0] addr_o,
  input logic [7:0]  wdata_o,
  input logic        ack_i,
  input logic        err_i
);
  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)));

  assert_rate_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_rate_o == 8'h0A) || (link_rate_o == 8'h06));

  assert_rate_fallback_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && (link_rate_o != $past(link_rate_o))) |-> (link_rate_o == 8'h06));

  assert_fail_pattern_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (tps_o == 2'd0));

  assert_err_fail_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && err_i) |=> (fail_o && !req_o));

  assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!req_o && !fail_o && !busy_o));
endmodule

bind dp_link_trainer dplt_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .link_rate_o (link_rate_o),
  .tps_o       (tps_o),
  .req_o       (req_o),
  .we_o        (we_o),
  .addr_o      (addr_o),
  .wdata_o     (wdata_o),
  .ack_i       (ack_i),
  .err_i       (err_i)
);

// File: tb/tb_dp_link_trainer.sv
module tb_dp_link_trainer;
  localparam int MAX_CR = 3;
  localparam int MAX_EQ = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, hbr_en_i = 1'b0;
  logic [2:0] lanes_i = 3'd4;
  logic busy_o, done_o, fail_o, req_o, we_o;
  logic [7:0] link_rate_o, wdata_o;
  logic [2:0] lane_count_o;
  logic [1:0] tps_o;
  logic [31:0] lane_ctl_o;
  logic [19:0] addr_o;
  logic ack_i = 1'b0, err_i = 1'b0;
  logic [7:0] rdata_i = 8'h00;

  dp_link_trainer #(.MAX_CR(MAX_CR), .MAX_EQ(MAX_EQ)) dut (.*);

  always #4 clk_i = ~clk_i;

  int total = 0, bad = 0, txn = 0, cyc = 0;
  bit aborted;
  // scenario knobs
  int n_lanes, cr_hi, cr_lo, eq_hi, eq_lo, mm_lane, err_at;
  bit hbr, cr_lost;
  int sw_a[4], em_a[4];

  task automatic chk(input bit c, input string tag, input string act, input string exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one sink access: compare, stall, answer
  task automatic xact(input bit ew, input logic [19:0] ea, input logic [7:0] ed,
                      input logic [7:0] rd, input string tag);
    int w;
    logic [19:0] sa; logic [7:0] sd; logic sw;
    bit e;
    if (aborted) return;
    w = 0;
    while (!req_o && w < 200) begin @(negedge clk_i); w++; end
    chk(req_o && we_o == ew && addr_o == ea && (!ew || wdata_o == ed), tag,
        $sformatf("req=%0b we=%0b a=%h d=%h", req_o, we_o, addr_o, wdata_o),
        $sformatf("req=1 we=%0b a=%h d=%h", ew, ea, ed));
    if (!(req_o && we_o == ew && addr_o == ea)) begin aborted = 1; return; end
    sa = addr_o; sd = wdata_o; sw = we_o;
    for (int k = 0; k < txn % 3; k++) begin
      @(negedge clk_i);
      chk(req_o && addr_o == sa && wdata_o == sd && we_o == sw, "R3 hold",
          $sformatf("req=%0b a=%h d=%h", req_o, addr_o, wdata_o),
          $sformatf("req=1 a=%h d=%h", sa, sd));
    end
    txn++;
    e = (txn == err_at);
    rdata_i = rd; err_i = e; ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0; err_i = 1'b0;
    if (e) aborted = 1;
  endtask

  function automatic logic [7:0] drv(input int s, input int m);
    logic [7:0] b;
    b = 8'((m << 3) | s);
    if (s == 3 || m == 3) b |= 8'h24;
    return b;
  endfunction

  function automatic logic [15:0] stat_pair(input logic [3:0] n);
    logic [15:0] v;
    for (int l = 0; l < 4; l++) v[l*4 +: 4] = (l == mm_lane) ? (n ^ 4'h8) : n;
    return v;
  endfunction

  task automatic run_case(input string name);
    int rate, ph, it, eqi, eq_loop;
    int crl[4];
    logic [7:0] ctl[4];
    logic [15:0] st, adj;
    logic [3:0] nb;
    bit red, ok, stp;
    logic [31:0] exp_ctl;
    for (int l = 0; l < 4; l++) adj[l*4 +: 4] = 4'((em_a[l] << 2) | sw_a[l]);
    aborted = 0; txn = 0;
    rate = hbr ? 'h0A : 'h06;
    @(negedge clk_i);
    hbr_en_i = hbr; lanes_i = 3'(n_lanes); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    ph = 0; ok = 0; it = 0; eqi = 0; eq_loop = 0;
    for (int l = 0; l < 4; l++) begin crl[l] = 0; ctl[l] = 8'h00; end
    while (ph < 4) begin
      if (aborted) begin ph = 5; break; end
      case (ph)
        0: begin // R2 start sequence
          for (int l = 0; l < 4; l++) begin crl[l] = 0; ctl[l] = 8'h00; end
          eq_loop = 0; it = 0; eqi = 0;
          xact(1, 20'h600, 8'h01, 0, "R2 power");
          xact(1, 20'h100, 8'(rate), 0, "R2 rate");
          xact(1, 20'h101, 8'(n_lanes), 0, "R2 lanes");
          xact(1, 20'h102, 8'h21, 0, "R2 pattern1");
          for (int l = 0; l < 4; l++) xact(1, 20'(32'h103 + l), 8'h00, 0, "R2 drive0");
          if (!aborted) begin
            chk(tps_o == 2'd1 && lane_count_o == 3'(n_lanes), "R2 locals",
                $sformatf("tps=%0d lc=%0d", tps_o, lane_count_o), $sformatf("tps=1 lc=%0d", n_lanes));
          end
          ph = 1;
        end
        1: begin // clock recovery iteration
          nb = (it >= ((rate == 'h0A) ? cr_hi : cr_lo)) ? 4'h1 : 4'h0;
          st = stat_pair(nb);
          xact(0, 20'h202, st[7:0], st[7:0], "R4 stat0");
          xact(0, 20'h203, st[15:8], st[15:8], "R4 stat1");
          xact(0, 20'h204, 0, 8'h00, "R4 align");
          xact(0, 20'h206, 0, adj[7:0], "R5 adj0");
          xact(0, 20'h207, 0, adj[15:8], "R5 adj1");
          if (aborted) begin ph = 5; break; end
          if (mm_lane < n_lanes) begin ph = 5; break; end
          if (nb[0]) begin
            for (int l = 0; l < n_lanes; l++) ctl[l] = drv(sw_a[l], em_a[l]);
            xact(1, 20'h102, 8'h22, 0, "R6 pattern2");
            for (int l = 0; l < 4; l++) xact(1, 20'(32'h103 + l), ctl[l], 0, "R6 drive");
            if (!aborted) chk(tps_o == 2'd2, "R6 tps", $sformatf("%0d", tps_o), "2");
            ph = 2;
          end else begin
            red = 0;
            for (int l = 0; l < n_lanes; l++) if (sw_a[l] == 3 || em_a[l] == 3) red = 1;
            if (!red) begin
              for (int l = 0; l < n_lanes; l++)
                if (ctl[l][1:0] == 2'(sw_a[l]) && ctl[l][4:3] == 2'(em_a[l])) begin
                  crl[l]++;
                  if (crl[l] == MAX_CR) red = 1;
                end
            end
            if (red) ph = 3;
            else begin
              for (int l = 0; l < n_lanes; l++) ctl[l] = drv(sw_a[l], em_a[l]);
              for (int l = 0; l < 4; l++) xact(1, 20'(32'h103 + l), ctl[l], 0, "R7 drive");
              it++;
            end
          end
        end
        2: begin // equalization iteration
          stp = (eqi >= ((rate == 'h0A) ? eq_hi : eq_lo));
          nb = {1'b0, stp, stp, !cr_lost};
          st = stat_pair(nb);
          xact(0, 20'h202, 0, st[7:0], "R4 stat0");
          xact(0, 20'h203, 0, st[15:8], "R4 stat1");
          xact(0, 20'h204, 0, {7'b0, stp}, "R8 align");
          xact(0, 20'h206, 0, adj[7:0], "R5 adj0");
          xact(0, 20'h207, 0, adj[15:8], "R5 adj1");
          if (aborted) begin ph = 5; break; end
          if (mm_lane < n_lanes) begin ph = 5; break; end
          if (cr_lost) ph = 3;                     // R10
          else if (stp) begin ph = 4; ok = 1; end  // R8
          else begin
            eq_loop++;
            if (eq_loop > MAX_EQ) ph = 3;          // R9
            else begin
              for (int l = 0; l < n_lanes; l++) ctl[l] = drv(sw_a[l], em_a[l]);
              for (int l = 0; l < 4; l++) xact(1, 20'(32'h103 + l), ctl[l], 0, "R9 drive");
              eqi++;
            end
          end
        end
        3: begin // R11 reduction
          if (rate == 'h0A) begin rate = 'h06; ph = 0; end
          else begin
            xact(1, 20'h102, 8'h00, 0, "R11 pattern off");
            ph = 5;
          end
        end
        default: ph = 5;
      endcase
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(!req_o, {name, " quiet R8/R12"}, $sformatf("req=%0b", req_o), "req=0");
    end
    for (int l = 0; l < 4; l++) exp_ctl[l*8 +: 8] = ctl[l];
    chk(done_o == ok && fail_o == !ok && !busy_o, {name, " outcome R8/R11"},
        $sformatf("done=%0b fail=%0b busy=%0b", done_o, fail_o, busy_o),
        $sformatf("done=%0b fail=%0b busy=0", ok, !ok));
    chk(link_rate_o == 8'(rate), {name, " rate R11"}, $sformatf("%h", link_rate_o), $sformatf("%h", rate));
    chk(tps_o == (ok ? 2'd2 : 2'd0), {name, " tps R11"}, $sformatf("%0d", tps_o), ok ? "2" : "0");
    chk(lane_ctl_o == exp_ctl, {name, " drive R5"}, $sformatf("%h", lane_ctl_o), $sformatf("%h", exp_ctl));
  endtask

  task automatic setup(input int ln, input bit h, input int ch, input int cl, input int eh,
                       input int el, input bit lost, input int mm, input int ea);
    n_lanes = ln; hbr = h; cr_hi = ch; cr_lo = cl; eq_hi = eh; eq_lo = el;
    cr_lost = lost; mm_lane = mm; err_at = ea;
  endtask

  task automatic set_adj(input int s0, input int e0, input int s1, input int e1,
                         input int s2, input int e2, input int s3, input int e3);
    sw_a[0] = s0; em_a[0] = e0; sw_a[1] = s1; em_a[1] = e1;
    sw_a[2] = s2; em_a[2] = e2; sw_a[3] = s3; em_a[3] = e3;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !fail_o && !req_o && tps_o == 0 && lane_ctl_o == 0 && link_rate_o == 8'h06,
        "R1 reset", $sformatf("b=%0b d=%0b f=%0b r=%0b t=%0d c=%h lr=%h", busy_o, done_o, fail_o,
        req_o, tps_o, lane_ctl_o, link_rate_o), "all idle, rate 06");

    // success at high rate, four lanes, varied requests
    set_adj(1, 0, 2, 1, 0, 2, 1, 1);
    setup(4, 1, 0, 0, 1, 1, 0, 9, 0);   run_case("basic4");
    // nibble of inactive lane differs: ignored (R4)
    set_adj(2, 0, 1, 2, 3, 3, 0, 0);
    setup(2, 1, 1, 1, 0, 0, 0, 3, 0);   run_case("inactive_ignored");
    // active lane disagrees: fail (R4)
    setup(4, 1, 0, 0, 0, 0, 0, 2, 0);   run_case("mismatch");
    // repeated drive setting exhausts clock recovery at both rates (R7, R11)
    set_adj(1, 1, 1, 1, 0, 0, 0, 0);
    setup(2, 1, 99, 99, 0, 0, 0, 9, 0); run_case("cr_repeat");
    // level-3 request forces fallback, then level-3 flags in drive byte (R5, R7)
    set_adj(3, 0, 0, 0, 0, 0, 0, 0);
    setup(1, 1, 99, 0, 0, 0, 0, 9, 0);  run_case("level3");
    // equalization loop exhausted at high rate, succeeds low (R9)
    set_adj(0, 1, 1, 0, 2, 0, 0, 2);
    setup(4, 1, 0, 0, 99, 1, 0, 9, 0);  run_case("eq_exhaust");
    // equalization exhausted at low rate: fail (R9, R11)
    setup(2, 0, 0, 0, 99, 99, 0, 9, 0); run_case("eq_exhaust_lo");
    // clock recovery lost during equalization (R10)
    setup(2, 1, 0, 0, 0, 0, 1, 9, 0);   run_case("eq_crlost");
    // error response mid-run (R12)
    setup(4, 1, 1, 1, 0, 0, 0, 9, 12);  run_case("err_resp");
    setup(4, 0, 0, 0, 0, 0, 0, 9, 1);   run_case("err_first");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule